// File: doc/BRIEF.md
# Condition Flag Generation Unit

This block produces the next negative, zero, carry and overflow flags for an integer datapath. From the result word, the operand and result sign bits, the adder's carry or borrow, the shifter's last shifted-out bit and a two-bit operation class, it builds the flag nibble to be written back into the status word. Each flag is written only by the operation classes that define it. Every other flag keeps its current value.

The same block also makes the execute decision for conditional instructions. A four-bit condition field is tested against the current flags, and the block drives a single execute signal. The execute path is always combinational. The new-flag path goes through a register when `REG_OUT` is 1, which is the default, and is a straight wire when `REG_OUT` is 0.

Top module: `flag_unit`

## Requirements
- R1: `newFlags` packs the flags as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V, the order of status-word bits 31..28. With `REG_OUT`=1 it reads 0000 while `rstN` is low. Otherwise it shows the flags computed from the inputs present at the previous rising edge.
- R2: With `setFlags` high, N takes the most significant bit of `result`, for every operation class.
- R3: With `setFlags` high, Z is 1 exactly when every bit of `result` is 0, for every operation class.
- R4: Class add (`opClass`=00): C equals `arithCarry` (the unsigned carry-out). V is 1 when `aSign` equals `bSign` and the result sign differs from `aSign`.
- R5: Class subtract (`opClass`=01): `arithCarry` carries the borrow and C is its inverse, so C is 0 on a borrow. V is 1 when `aSign` differs from `bSign` and the result sign differs from `aSign`.
- R6: Class logical-with-shift (`opClass`=10): C equals `shiftCarry` and V keeps its current value.
- R7: Class logical-without-shift (`opClass`=11): C and V both keep their current values.
- R8: With `setFlags` low, all four flags keep their current values, whatever the other inputs are.
- R9: `execute` follows this table of condition codes:
  - 0000: Z
  - 0001: !Z
  - 0010: C
  - 0011: !C
  - 0100: N
  - 0101: !N
  - 0110: V
  - 0111: !V
  - 1000: C & !Z
  - 1001: !C | Z
  - 1010: N==V
  - 1011: N!=V
  - 1100: !Z & (N==V)
  - 1101: Z | (N!=V)
- R10: Condition code 1110 always executes. Condition code 1111 never executes.
- R11: `execute` is combinational in `condCode` and `curFlags`. It changes in the same cycle as its inputs, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| opClass | input | 2 | Operation class: 00 add, 01 subtract, 10 logical with shift, 11 logical |
| result | input | DATA_W | Result word of the operation |
| aSign | input | 1 | Sign bit of the first operand |
| bSign | input | 1 | Sign bit of the second operand as presented to the operation |
| arithCarry | input | 1 | Adder carry-out for add, borrow for subtract |
| shiftCarry | input | 1 | Last bit shifted out by the shifter |
| setFlags | input | 1 | Flag update enable |
| curFlags | input | 4 | Current flags, {N,Z,C,V} |
| condCode | input | 4 | Condition field of the instruction |
| newFlags | output | 4 | Next flags, {N,Z,C,V} |
| execute | output | 1 | Instruction passes its condition |

## Verification
The embedded properties check, on every cycle, that a disabled update holds all four flags, that N and Z follow the result, that the plain logical class leaves C and V alone, and that codes 1110 and 1111 force the execute signal. The signed overflow rules, the inversion of the borrow on subtract, the choice of the shifter carry and the full fourteen-entry condition table can only be shown by the bench. Its sweeps run every operation class against every current flag value, every sign combination and boundary result words, and compare the results with values computed arithmetically.

// File: rtl/flagunit_pkg.sv
`timescale 1ns/1ps
package flagunit_pkg;

  localparam int FLAG_W = 4;

  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_SUB   = 2'b01,
    OP_LOGSH = 2'b10,
    OP_LOGIC = 2'b11
  } op_class_e;

  // Flag nibble ordering N,Z,C,V from msb down
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic updNZ;
    logic updC;
    logic cFromShift;
    logic cInvert;
    logic updV;
    logic vSubtract;
  } flag_strobes_t;

endpackage

// File: rtl/flag_ctrl.sv
`timescale 1ns/1ps
module flag_ctrl
  import flagunit_pkg::*;
(
  input  op_class_e     opClass,
  input  logic          setFlags,
  input  logic [3:0]    condCode,
  input  flags_t        curFlags,
  output flag_strobes_t strobes,
  output logic          execute
);

  logic baseCond;

  always_comb begin
    strobes = '0;
    if (setFlags) begin
      strobes.updNZ = 1'b1;
      unique case (opClass)
        OP_ADD: begin
          strobes.updC = 1'b1;
          strobes.updV = 1'b1;
        end
        OP_SUB: begin
          strobes.updC      = 1'b1;
          strobes.cInvert   = 1'b1;
          strobes.updV      = 1'b1;
          strobes.vSubtract = 1'b1;
        end
        OP_LOGSH: begin
          strobes.updC       = 1'b1;
          strobes.cFromShift = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // Condition pairs share a base test; the low code bit inverts it
  always_comb begin
    unique case (condCode[3:1])
      3'd0:    baseCond = curFlags.z;
      3'd1:    baseCond = curFlags.c;
      3'd2:    baseCond = curFlags.n;
      3'd3:    baseCond = curFlags.v;
      3'd4:    baseCond = curFlags.c & ~curFlags.z;
      3'd5:    baseCond = (curFlags.n == curFlags.v);
      3'd6:    baseCond = ~curFlags.z & (curFlags.n == curFlags.v);
      default: baseCond = 1'b1;
    endcase
  end

  assign execute = baseCond ^ condCode[0];

endmodule

// File: rtl/flag_datapath.sv
`timescale 1ns/1ps
module flag_datapath
  import flagunit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  flag_strobes_t      strobes,
  input  logic [DATA_W-1:0]  result,
  input  logic               aSign,
  input  logic               bSign,
  input  logic               arithCarry,
  input  logic               shiftCarry,
  input  flags_t             curFlags,
  output flags_t             nextFlags
);

  localparam int MSB = DATA_W - 1;

  logic resSign;
  logic resZero;
  logic addOvf;
  logic subOvf;

  assign resSign = result[MSB];
  assign resZero = ~|result;
  assign addOvf  = (aSign == bSign) && (resSign != aSign);
  assign subOvf  = (aSign != bSign) && (resSign != aSign);

  always_comb begin
    nextFlags = curFlags;
    if (strobes.updNZ) begin
      nextFlags.n = resSign;
      nextFlags.z = resZero;
    end
    if (strobes.updC)
      nextFlags.c = strobes.cFromShift ? shiftCarry : (arithCarry ^ strobes.cInvert);
    if (strobes.updV)
      nextFlags.v = strobes.vSubtract ? subOvf : addOvf;
  end

endmodule

// File: rtl/flag_unit.sv
`timescale 1ns/1ps
module flag_unit
  import flagunit_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        opClass,
  input  logic [DATA_W-1:0] result,
  input  logic              aSign,
  input  logic              bSign,
  input  logic              arithCarry,
  input  logic              shiftCarry,
  input  logic              setFlags,
  input  logic [3:0]        curFlags,
  input  logic [3:0]        condCode,
  output logic [3:0]        newFlags,
  output logic              execute
);

  flag_strobes_t strobes;
  flags_t        nextFlags;

  flag_ctrl uCtrl (
    .opClass  (op_class_e'(opClass)),
    .setFlags (setFlags),
    .condCode (condCode),
    .curFlags (flags_t'(curFlags)),
    .strobes  (strobes),
    .execute  (execute)
  );

  flag_datapath #(.DATA_W(DATA_W)) uDp (
    .strobes    (strobes),
    .result     (result),
    .aSign      (aSign),
    .bSign      (bSign),
    .arithCarry (arithCarry),
    .shiftCarry (shiftCarry),
    .curFlags   (flags_t'(curFlags)),
    .nextFlags  (nextFlags)
  );

  generate
    if (REG_OUT) begin : gReg
      logic [FLAG_W-1:0] flagsQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) flagsQ <= '0;
        else       flagsQ <= nextFlags;
      end
      assign newFlags = flagsQ;

      // R8: disabled update holds all flags
      a_r8_hold_all: assert property (@(posedge clk) disable iff (!rstN)
        !setFlags |=> newFlags == $past(curFlags));
      // R2: N follows result sign
      a_r2_n_sign: assert property (@(posedge clk) disable iff (!rstN)
        setFlags |=> newFlags[3] == $past(result[DATA_W-1]));
      // R3: Z flags an all-zero result
      a_r3_z_zero: assert property (@(posedge clk) disable iff (!rstN)
        setFlags |=> newFlags[2] == ($past(result) == '0));
      // R7: plain logical class keeps C and V
      a_r7_keep_cv: assert property (@(posedge clk) disable iff (!rstN)
        (setFlags && opClass == 2'b11) |=> newFlags[1:0] == $past(curFlags[1:0]));
      // R10: fixed codes
      a_r10_always: assert property (@(posedge clk) disable iff (!rstN)
        condCode == 4'b1110 |-> execute);
      a_r10_never: assert property (@(posedge clk) disable iff (!rstN)
        condCode == 4'b1111 |-> !execute);
    end else begin : gComb
      assign newFlags = nextFlags;
    end
  endgenerate

endmodule

// File: tb/flag_unit_test.sv
`timescale 1ns/1ps
module flag_unit_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  opClass;
  logic [31:0] result;
  logic        aSign, bSign, arithCarry, shiftCarry, setFlags;
  logic [3:0]  curFlags, condCode;
  logic [3:0]  newFlags;
  logic        execute;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flag_unit uut (
    .clk(clk), .rstN(rstN), .opClass(opClass), .result(result),
    .aSign(aSign), .bSign(bSign), .arithCarry(arithCarry),
    .shiftCarry(shiftCarry), .setFlags(setFlags), .curFlags(curFlags),
    .condCode(condCode), .newFlags(newFlags), .execute(execute)
  );

  task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input int k);
    case (k)
      0:       return 32'h0000_0000;
      1:       return 32'h8000_0000;
      2:       return 32'h0000_0001;
      3:       return 32'h7FFF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic expCond(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return c;
      4'h3: return !c;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return c && !z;
      4'h9: return !c || z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; opClass = 2'b00; result = 32'h1234_5678; aSign = 1'b1; bSign = 1'b1;
    arithCarry = 1'b1; shiftCarry = 1'b1; setFlags = 1'b1; curFlags = 4'hF; condCode = 4'h0;
    repeat (3) @(negedge clk);
    check4("R1 reset", newFlags, 4'b0000);
    rstN = 1'b1;

    // Flag generation sweep
    for (int oc = 0; oc < 4; oc++)
      for (int sf = 0; sf < 2; sf++)
        for (int cf = 0; cf < 16; cf++)
          for (int rp = 0; rp < 5; rp++)
            for (int bits = 0; bits < 16; bits++) begin
              logic [3:0] expF;
              logic rs;
              string req;
              @(negedge clk);
              opClass = oc[1:0]; setFlags = sf[0]; curFlags = cf[3:0];
              result = pattern(rp);
              aSign = bits[0]; bSign = bits[1]; arithCarry = bits[2]; shiftCarry = bits[3];
              rs = result[31];
              expF = curFlags;
              if (setFlags) begin
                expF[3] = rs;
                expF[2] = (result == 32'd0);
                case (oc)
                  0: begin expF[1] = arithCarry;  expF[0] = (aSign == bSign) && (rs != aSign); end
                  1: begin expF[1] = !arithCarry; expF[0] = (aSign != bSign) && (rs != aSign); end
                  2: expF[1] = shiftCarry;
                  default: ;
                endcase
              end
              if (!setFlags)    req = "R8 hold";
              else if (oc == 0) req = "R4 add";
              else if (oc == 1) req = "R5 sub";
              else if (oc == 2) req = "R6 logical-shift";
              else              req = "R7 logical";
              @(negedge clk);
              check4({req, " R1 order"}, newFlags, expF);
              if (setFlags) begin
                check4("R2 N", {3'b0, newFlags[3]}, {3'b0, expF[3]});
                check4("R3 Z", {3'b0, newFlags[2]}, {3'b0, expF[2]});
              end
            end

    // Condition table sweep, combinational sampling
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++) begin
        @(negedge clk);
        condCode = cc[3:0]; curFlags = f[3:0];
        #1;
        if (cc >= 14) check4("R10 fixed code", {3'b0, execute}, {3'b0, expCond(cc[3:0], f[3:0])});
        else          check4("R9 cond table", {3'b0, execute}, {3'b0, expCond(cc[3:0], f[3:0])});
      end

    // R11: execute responds within the same cycle
    @(posedge clk);
    #1;
    condCode = 4'h0; curFlags = 4'b0100;
    #1;
    check4("R11 same-cycle set", {3'b0, execute}, 4'b0001);
    curFlags = 4'b0000;
    #1;
    check4("R11 same-cycle clear", {3'b0, execute}, 4'b0000);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule